// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous static memory with a shared data path: every control and address input is taken on the rising clock edge, and read data leaves through an output register. An access begins on a processor strobe or a controller strobe while all three chip selects are true. A read shows its word on the data pins one edge after the address edge. A write started by the controller strobe completes on that same edge. A write started by the processor strobe completes on the edge after it. Each word is four byte lanes of nine bits, eight data bits and one parity bit. A global write, or a byte-write enable together with per-lane selects, chooses which lanes are written.

The pins are split into a data-in bus, a data-out bus and one driver-enable output. The enable is the output-register valid state gated by an asynchronous, active-low output enable. Detected writes, deselect edges and the first cycle after leaving the deselected state all force the enable low. The address port is 17 bits wide. The behavioural array decodes the low `ARRAY_AW` bits, so higher addresses alias onto it. Burst address sequencing belongs to a separate sequencer and is not part of this block.

Top module: `pbsram_ctrl`

## Requirements
- R1: While `rst` is high, and after its release until a read completes, `dout_drv` is 0.
- R2: A read starts on an edge where `proc_stb_n` or `ctrl_stb_n` is 0, the chip selects are all true (`cs0_n`=0, `cs1`=1, `cs2_n`=0) and both `wr_all_n` and `lane_wr_en_n` are 1. Its word is on `dout`, with `dout_drv`=1, after the next edge.
- R3: When `cs0_n` is 1, a low `proc_stb_n` has no effect. With `ctrl_stb_n` high, the bus keeps its present word and drive state.
- R4: An access started by `proc_stb_n` ignores the write controls and data on its first edge. If write controls are asserted on the following edge, with no strobe low, `din` at that edge is written to the captured address.
- R5: `ctrl_stb_n`=0 with `proc_stb_n`=1, the chip selects true and write controls asserted writes `din` on that same edge.
- R6: `wr_all_n`=0 writes all four lanes, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R7: With `wr_all_n`=1, lane i is written only when `lane_wr_en_n`=0 and `lane_sel_n[i]`=0. Other lanes keep their contents. With `lane_wr_en_n`=1, nothing is written and the access is a read.
- R8: Lane i occupies `din`/`dout` bits [9i+8:9i]; bit 9i+8 is its parity bit and `lane_sel_n[i]` controls it.
- R9: An edge where a strobe is taken while the chip selects are not all true is a deselect: `dout_drv` is 0 from that edge on.
- R10: After an edge on which any lane is written, `dout_drv` is 0 whatever `out_en_n` is.
- R11: `out_en_n` gates `dout_drv` asynchronously, within the cycle, while the output register holds read data.
- R12: Reads started on consecutive edges deliver their words on consecutive edges.
- R13: An access started from the deselected state leaves `dout_drv` at 0 during its first cycle. An access started while selected leaves the previous word driven during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 17 | Word address, taken on strobe edges |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| cs0_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data, four 9-bit lanes |
| dout | output | 36 | Registered read data |
| dout_drv | output | 1 | Driver enable for the shared data pins |

## Verification
A pending read can complete on the same edge that carries a controller-strobe write. The write must land, and the bus must be forced off, not show the read word. The bench provokes this by starting a read while earlier data is being driven and then strobing a write on the very next edge. It judges the result from `dout_drv` after that edge and from a later read of the written address. A processor-strobe write also meets a possible new strobe on its second edge. The bench drives junk data and active write controls on the first edge and checks that only the second-edge data and lanes reach the array.

// File: rtl/pbsram_pkg.sv
`timescale 1ns/1ps
package pbsram_pkg;

  // Per-edge decode of strobes and chip selects
  typedef struct packed {
    logic proc_go;   // processor strobe starts an access
    logic ctrl_go;   // controller strobe starts an access
    logic deselect;  // strobe taken with chip selects not all true
    logic wr_any;    // at least one lane requested for writing
  } dec_t;

endpackage

// File: rtl/pbsram_decode.sv
`timescale 1ns/1ps
module pbsram_decode
  import pbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             proc_stb_n,
  input  logic             ctrl_stb_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output dec_t             dec,
  output logic [LANES-1:0] lane_mask
);

  logic sel_all;

  always_comb begin
    sel_all = ~cs0_n & cs1 & ~cs2_n;

    // global write wins over the byte path
    if (!wr_all_n)          lane_mask = '1;
    else if (!lane_wr_en_n) lane_mask = ~lane_sel_n;
    else                    lane_mask = '0;

    dec.proc_go  = ~proc_stb_n & sel_all;
    dec.ctrl_go  = ~ctrl_stb_n & proc_stb_n & sel_all;
    // processor strobe only counts when the first select is low
    dec.deselect = (~proc_stb_n & ~cs0_n & ~sel_all) |
                   (~ctrl_stb_n & ~sel_all);
    dec.wr_any   = |lane_mask;
  end

endmodule

// File: rtl/pbsram_seq.sv
`timescale 1ns/1ps
module pbsram_seq
  import pbsram_pkg::*;
#(
  parameter int LANES = 4,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dec_t             dec,
  input  logic [LANES-1:0] lane_mask,
  input  logic [AW-1:0]    addr,
  output logic [LANES-1:0] lane_we,
  output logic [AW-1:0]    waddr,
  output logic [AW-1:0]    raddr,
  output logic             rd_en,
  output logic             data_vld
);

  logic [AW-1:0] addr_q;
  logic          rd_pend_q;
  logic          proc_pend_q;
  logic          sel_q;
  logic          vld_q;

  logic start, ctrl_wr, proc_wr, wr_now, rd_fire;

  always_comb begin
    start   = dec.proc_go | dec.ctrl_go;
    ctrl_wr = dec.ctrl_go & dec.wr_any;
    // second edge of a processor-strobe access, no new strobe taken
    proc_wr = proc_pend_q & ~start & ~dec.deselect & dec.wr_any;
    wr_now  = ctrl_wr | proc_wr;
    rd_fire = rd_pend_q & ~proc_wr & ~dec.deselect;
  end

  assign lane_we  = wr_now ? lane_mask : '0;
  assign waddr    = ctrl_wr ? addr : addr_q;
  assign raddr    = addr_q;
  assign rd_en    = rd_fire & ~wr_now;
  assign data_vld = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      rd_pend_q   <= 1'b0;
      proc_pend_q <= 1'b0;
      sel_q       <= 1'b0;
      vld_q       <= 1'b0;
    end else begin
      if (start) addr_q <= addr;
      rd_pend_q   <= start & ~ctrl_wr;
      proc_pend_q <= dec.proc_go;
      if (start)             sel_q <= 1'b1;
      else if (dec.deselect) sel_q <= 1'b0;
      if (wr_now || dec.deselect) vld_q <= 1'b0;
      else if (rd_fire)           vld_q <= 1'b1;
      else if (start && !sel_q)   vld_q <= 1'b0;
    end
  end

  // R13: leaving the deselected state never drives in the first cycle
  a_r13_first_cycle_off: assert property (@(posedge clk) disable iff (rst)
    (start && !sel_q) |=> !data_vld);

  // R4: the opening edge of a processor-strobe access writes nothing
  a_r4_proc_edge_no_write: assert property (@(posedge clk) disable iff (rst)
    dec.proc_go |-> (lane_we == '0));

endmodule

// File: rtl/pbsram_array.sv
`timescale 1ns/1ps
module pbsram_array #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int AW     = 8
) (
  input  logic                        clk,
  input  logic [LANES-1:0]            we,
  input  logic [AW-1:0]               waddr,
  input  logic [LANES*(BYTE_W+1)-1:0] wdata,
  input  logic                        re,
  input  logic [AW-1:0]               raddr,
  output logic [LANES*(BYTE_W+1)-1:0] rdata
);

  localparam int LANE_W = BYTE_W + 1;
  localparam int DEPTH  = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    q <= mem[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/pbsram_ctrl.sv
`timescale 1ns/1ps
module pbsram_ctrl
  import pbsram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LANES    = 4,
  parameter int BYTE_W   = 8,
  parameter int ARRAY_AW = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        proc_stb_n,
  input  logic                        ctrl_stb_n,
  input  logic                        cs0_n,
  input  logic                        cs1,
  input  logic                        cs2_n,
  input  logic                        wr_all_n,
  input  logic                        lane_wr_en_n,
  input  logic [LANES-1:0]            lane_sel_n,
  input  logic                        out_en_n,
  input  logic [LANES*(BYTE_W+1)-1:0] din,
  output logic [LANES*(BYTE_W+1)-1:0] dout,
  output logic                        dout_drv
);

  dec_t                dec;
  logic [LANES-1:0]    lane_mask;
  logic [LANES-1:0]    lane_we;
  logic [ARRAY_AW-1:0] waddr, raddr;
  logic                rd_en;
  logic                data_vld;

  if (ADDR_W > ARRAY_AW) begin : g_alias
    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:ARRAY_AW];
  end

  pbsram_decode #(.LANES(LANES)) u_dec (
    .proc_stb_n  (proc_stb_n),
    .ctrl_stb_n  (ctrl_stb_n),
    .cs0_n       (cs0_n),
    .cs1         (cs1),
    .cs2_n       (cs2_n),
    .wr_all_n    (wr_all_n),
    .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n  (lane_sel_n),
    .dec         (dec),
    .lane_mask   (lane_mask)
  );

  pbsram_seq #(.LANES(LANES), .AW(ARRAY_AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .dec      (dec),
    .lane_mask(lane_mask),
    .addr     (addr[ARRAY_AW-1:0]),
    .lane_we  (lane_we),
    .waddr    (waddr),
    .raddr    (raddr),
    .rd_en    (rd_en),
    .data_vld (data_vld)
  );

  pbsram_array #(.LANES(LANES), .BYTE_W(BYTE_W), .AW(ARRAY_AW)) u_arr (
    .clk  (clk),
    .we   (lane_we),
    .waddr(waddr),
    .wdata(din),
    .re   (rd_en),
    .raddr(raddr),
    .rdata(dout)
  );

  // asynchronous output-enable gate on the registered valid state
  assign dout_drv = data_vld & ~out_en_n;

  // R10: a written edge leaves the drivers off
  a_r10_write_blanks: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |=> !dout_drv);

  // R9: a deselect edge turns the drivers off
  a_r9_deselect_off: assert property (@(posedge clk) disable iff (rst)
    dec.deselect |=> !dout_drv);

  // R6: a global write touches every lane
  a_r6_global_all: assert property (@(posedge clk) disable iff (rst)
    ((|lane_we) && !wr_all_n) |-> (&lane_we));

  // R2: a completed read drives exactly as the output enable allows
  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (dout_drv == !out_en_n));

endmodule

// File: tb/pbsram_ctrl_tb.sv
`timescale 1ns/1ps
module pbsram_ctrl_tb_top;

  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst;
  logic [16:0]   addr;
  logic          proc_stb_n, ctrl_stb_n, cs0_n, cs1, cs2_n;
  logic          wr_all_n, lane_wr_en_n, out_en_n;
  logic [3:0]    lane_sel_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_drv;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;
  logic [DW-1:0] ref_mem [256];

  always #2.5 clk = ~clk;

  pbsram_ctrl dut_i (
    .clk(clk), .rst(rst), .addr(addr),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .din(din), .dout(dout), .dout_drv(dout_drv)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1;
    cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
  endtask

  function automatic logic [3:0] lanes_of(logic g, logic be, logic [3:0] bw);
    if (!g)       return 4'hF;
    else if (!be) return ~bw;
    else          return 4'h0;
  endfunction

  task automatic model_wr(int a, logic [DW-1:0] d, logic [3:0] m);
    for (int i = 0; i < LANES; i++)
      if (m[i]) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic rd_start(int a);
    idle(); ctrl_stb_n = 1'b0; addr = 17'(a);
    tick(); idle();
  endtask

  task automatic do_read(int a, string req);
    rd_start(a);
    tick();
    chk(req, DW'(dout_drv), DW'(1));
    chk(req, dout, ref_mem[a]);
  endtask

  task automatic wr_ctrl(int a, logic [DW-1:0] d, logic g, logic be, logic [3:0] bw);
    idle(); ctrl_stb_n = 1'b0; addr = 17'(a);
    wr_all_n = g; lane_wr_en_n = be; lane_sel_n = bw; din = d;
    tick(); idle();
    model_wr(a, d, lanes_of(g, be, bw));
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk("R1 drv in reset", DW'(dout_drv), DW'(0));
    @(negedge clk); rst = 1'b0;
    tick();
    chk("R1 drv after reset", DW'(dout_drv), DW'(0));
  endtask

  task automatic t_ctrl_write();
    wr_ctrl(3, 36'h1_2345_6789, 1'b0, 1'b1, 4'hF);
    wr_ctrl(4, 36'hA_BCDE_F012, 1'b0, 1'b1, 4'hF);
    wr_ctrl(5, 36'h5_5AA5_5AA5, 1'b0, 1'b1, 4'hF);
    wr_ctrl(6, 36'h0_0000_0000, 1'b0, 1'b1, 4'hF);
    do_read(3, "R5 single-edge write");
    // global write with partial byte selects still hits all lanes
    wr_ctrl(4, 36'h3_C3C3_C3C3, 1'b0, 1'b0, 4'b1110);
    do_read(4, "R6 global overrides lanes");
  endtask

  task automatic t_latency();
    do_read(3, "R2 read");
    rd_start(5);
    chk("R2 old word held", dout, ref_mem[3]);
    tick();
    chk("R2 new word", dout, ref_mem[5]);
    // read via processor strobe
    idle(); proc_stb_n = 1'b0; addr = 17'd4;
    tick(); idle();
    tick();
    chk("R2 proc read", dout, ref_mem[4]);
  endtask

  task automatic t_bytes();
    logic [DW-1:0] old5;
    old5 = ref_mem[5];
    wr_ctrl(5, 36'hF_0F0F_0F0F, 1'b1, 1'b0, 4'b0111);
    rd_start(5); tick();
    chk("R8 lane3 bits 35:27", DW'(dout[35:27]), DW'(9'h1E1));
    chk("R7 other lanes kept", DW'(dout[26:0]), DW'(old5[26:0]));
    wr_ctrl(5, 36'h0_0000_0000, 1'b1, 1'b1, 4'h0);
    do_read(5, "R7 enable high no write");
  endtask

  task automatic t_proc_write();
    logic [DW-1:0] d;
    d = 36'h9_8765_4321;
    do_read(6, "R4 setup");
    idle(); proc_stb_n = 1'b0; addr = 17'd6;
    wr_all_n = 1'b0; din = ~d;            // ignored on first edge
    tick(); idle();
    lane_wr_en_n = 1'b0; lane_sel_n = 4'b1010; din = d; addr = 17'd7;
    tick(); idle();
    chk("R10 drv off after proc write", DW'(dout_drv), DW'(0));
    model_wr(6, d, 4'b0101);
    do_read(6, "R4 two-edge write");
  endtask

  task automatic t_oe();
    do_read(3, "R11 setup");
    #1 out_en_n = 1'b1;
    #1 chk("R11 oe high", DW'(dout_drv), DW'(0));
    out_en_n = 1'b0;
    #1 chk("R11 oe low", DW'(dout_drv), DW'(1));
  endtask

  task automatic t_ignore();
    do_read(3, "R3 setup");
    idle(); proc_stb_n = 1'b0; cs0_n = 1'b1; addr = 17'd5;
    tick(); idle();
    chk("R3 drv kept", DW'(dout_drv), DW'(1));
    tick();
    chk("R3 word kept", dout, ref_mem[3]);
  endtask

  task automatic t_deselect_first();
    do_read(4, "R9 setup");
    idle(); ctrl_stb_n = 1'b0; cs1 = 1'b0;
    tick(); idle();
    chk("R9 ctrl deselect", DW'(dout_drv), DW'(0));
    rd_start(3);
    chk("R13 first cycle off", DW'(dout_drv), DW'(0));
    tick();
    chk("R13 then driven", dout, ref_mem[3]);
    idle(); proc_stb_n = 1'b0; cs2_n = 1'b1;
    tick(); idle();
    chk("R9 proc deselect", DW'(dout_drv), DW'(0));
    do_read(5, "R13 reselect");
    rd_start(6);
    chk("R13 selected keeps word", DW'(dout_drv), DW'(1));
    tick();
  endtask

  task automatic t_pipe();
    idle(); ctrl_stb_n = 1'b0; addr = 17'd3;
    tick(); addr = 17'd4;
    tick();
    chk("R12 first", dout, ref_mem[3]);
    addr = 17'd5;
    tick();
    chk("R12 second", dout, ref_mem[4]);
    idle();
    tick();
    chk("R12 third", dout, ref_mem[5]);
  endtask

  task automatic t_overlap();
    do_read(3, "R10 setup");
    rd_start(5);
    wr_ctrl(6, 36'h7_1111_2222, 1'b0, 1'b1, 4'hF);
    chk("R10 write beats read", DW'(dout_drv), DW'(0));
    do_read(6, "R10 write landed");
  endtask

  initial begin
    rst = 1'b1; out_en_n = 1'b0; addr = '0; din = '0;
    idle();
    repeat (3) tick();
    t_reset();
    t_ctrl_write();
    t_latency();
    t_bytes();
    t_proc_write();
    t_oe();
    t_ignore();
    t_deselect_first();
    t_pipe();
    t_overlap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule